// File: doc/BRIEF.md
# TCP Connection State Classifier

This block sits in front of a packet inspection engine and decides, for every TCP header it is shown, what the datapath should do with the packet. It keeps one record per connection in an on-chip table addressed by a fold of the connection's 4-tuple. Each record remembers the owning tuple, the next byte number the connection is expected to deliver, whether the connection has been opened and acknowledged, and which reorder buffer (if any) it holds. The header supplies the tuple, the SYN and ACK flags, the sequence number, the payload length and a checksum verdict.

A header is taken in any cycle where `hdr_valid` and `hdr_ready` are both high. One cycle later the block reports a single action: hand to the application, pass to the network only, hold in a reorder buffer, or discard. The index of the record used and, for held packets, the reorder buffer id come with it. The record is rewritten on that same edge, so a following header, even one in the very next cycle, sees the update. Because collisions in the table are resolved by policy, a new connection may displace one that has not yet finished opening. An established connection keeps its slot.

After reset the block wipes the table one entry per cycle and holds `hdr_ready` low until the wipe is complete.

Top module: `tcp_conn_classifier`

## Requirements
- R1: After reset is released, `hdr_ready` stays low for exactly 2^IDX_W cycles while every record is cleared, then stays high. No action is reported while it is low.
- R2: The record index is the XOR of all IDX_W-bit slices of the 96-bit tuple {src_ip, dst_ip, src_port, dst_port}, with src_ip in the top bits and the top slice zero-padded. An accepted header produces `act_valid` high for exactly one cycle, on the edge after acceptance, with `act_index` equal to that index. Action codes are 0 discard, 1 application, 2 forward-only, 3 buffer.
- R3: A header whose `csum_ok` is low is discarded and leaves its record unchanged.
- R4: A SYN that reaches an unoccupied record goes to the application. The record then holds its tuple, is marked opened without acknowledgement, has no reorder buffer, and expects seq + length + 1.
- R5: A packet of the owning tuple whose sequence equals the expected number goes to the application. The expected number then advances by the payload length, plus one if SYN is set.
- R6: A packet of the owning tuple whose sequence lies behind the expected number is forward-only and leaves the expected number unchanged.
- R7: A packet of the owning tuple whose sequence lies ahead of the expected number is buffered and leaves the expected number unchanged. If the record has no reorder buffer, it receives the next id from a counter that starts at 1, counts up per allocation and never yields 0. An existing id is reused, and `act_seg` reports the id (0 for other actions).
- R8: A SYN of a different tuple that reaches an occupied record whose ACK mark is clear evicts the occupant and is installed as in R4.
- R9: A SYN of a different tuple that reaches an occupied record whose ACK mark is set is discarded and leaves the occupant untouched.
- R10: A non-SYN packet whose tuple does not own its record (or whose record is empty) is forward-only and changes nothing.
- R11: A packet of the owning tuple that carries ACK sets the record's ACK mark.
- R12: Ahead/behind decisions use the 32-bit difference seq − expected taken as a signed number, so they hold across sequence wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header accepted this cycle when valid |
| src_ip | input | 32 | Source address |
| dst_ip | input | 32 | Destination address |
| src_port | input | 16 | Source port |
| dst_port | input | 16 | Destination port |
| flag_syn | input | 1 | SYN flag |
| flag_ack | input | 1 | ACK flag |
| seq_num | input | 32 | Sequence number |
| pay_len | input | 16 | Payload length in bytes |
| csum_ok | input | 1 | Checksum verdict |
| act_valid | output | 1 | Action strobe |
| act_code | output | 2 | Action: 0 discard, 1 application, 2 forward-only, 3 buffer |
| act_index | output | IDX_W | Record index used |
| act_seg | output | 8 | Reorder buffer id for buffered packets, else 0 |

## Verification
The hardest state to reach from the ports is a hash collision between two live tuples, one with an unacknowledged occupant and one with an acknowledged one. This is because the index is a fold of 96 bits. The stimulus builds colliding pairs by flipping one bit in each of two slices of the source port, which cancels in the XOR fold. It then tests eviction and protection in turn, and checks that the survivor keeps its expected number by sending it an in-order packet afterwards. A wrap-around connection placed just below 2^32 drives the signed-difference comparison across zero.

// File: rtl/tcpc_pkg.sv
// Shared widths, action encoding and record layout for the TCP
// connection classifier. Assumes IPv4 tuples and 32-bit sequence space.
package tcpc_pkg;
    localparam int TUPLE_W   = 96;
    localparam int SEQ_W     = 32;
    localparam int LEN_W     = 16;
    localparam int SEG_PTR_W = 8;

    typedef enum logic [1:0] {
        ACT_DROP = 2'd0,
        ACT_APP  = 2'd1,
        ACT_FWD  = 2'd2,
        ACT_BUF  = 2'd3
    } act_e;

    typedef struct packed {
        logic                 est;
        logic                 syn;
        logic                 ack;
        logic [TUPLE_W-1:0]   tuple;
        logic [SEQ_W-1:0]     exp_seq;
        logic [SEG_PTR_W-1:0] seg_ptr;
    } conn_rec_t;
endpackage

// File: rtl/tcpc_hash.sv
// Folds the 96-bit connection tuple to a table index by XOR of all
// IDX_W-bit slices. Purely combinational; top slice is zero-padded.
module tcpc_hash
    import tcpc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [TUPLE_W-1:0] tuple,
    output logic [IDX_W-1:0]   idx
);
    localparam int NSLICE = (TUPLE_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = NSLICE * IDX_W;

    logic [PAD_W-1:0] padded;
    assign padded = PAD_W'(tuple);

    // XOR every slice together
    always_comb begin
        idx = '0;
        for (int i = 0; i < NSLICE; i++) begin
            idx = idx ^ padded[i*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/tcpc_table.sv
// Connection record store: asynchronous read, single synchronous write.
// After reset it clears one entry per cycle and reports ready only when
// the sweep is done. Writes requested during the sweep are ignored;
// the caller must gate them with ready.
module tcpc_table
    import tcpc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output conn_rec_t        rd_rec,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  conn_rec_t        wr_rec,
    output logic             ready
);
    localparam int DEPTH = 1 << IDX_W;

    conn_rec_t        mem [DEPTH];
    logic [IDX_W:0]   sweep;

    assign ready  = sweep[IDX_W];
    assign rd_rec = mem[rd_idx];

    // Sweep counter: runs from 0 to DEPTH once after reset
    always_ff @(posedge clk) begin
        if (!rst_n)       sweep <= '0;
        else if (!ready)  sweep <= sweep + 1'b1;
    end

    // Storage: clear during sweep, then accept policy writes
    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (!ready)   mem[sweep[IDX_W-1:0]] <= '0;
            else if (we)  mem[wr_idx] <= wr_rec;
        end
    end

    assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
endmodule

// File: rtl/tcpc_policy.sv
// Combinational handshake, collision and ordering policy. Given the
// current record and a header, produces the action, the record to
// write back and whether a reorder buffer id is consumed.
module tcpc_policy
    import tcpc_pkg::*;
(
    input  conn_rec_t            cur,
    input  logic [TUPLE_W-1:0]   tuple,
    input  logic                 flag_syn,
    input  logic                 flag_ack,
    input  logic [SEQ_W-1:0]     seq_num,
    input  logic [LEN_W-1:0]     pay_len,
    input  logic                 csum_ok,
    input  logic [SEG_PTR_W-1:0] next_ptr,
    output act_e                 act,
    output conn_rec_t            nxt,
    output logic                 we,
    output logic                 alloc
);
    logic             owner;
    logic [SEQ_W-1:0] diff;
    logic [SEQ_W-1:0] advanced;

    assign owner    = cur.est && (cur.tuple == tuple);
    assign diff     = seq_num - cur.exp_seq;
    assign advanced = seq_num + SEQ_W'(pay_len) + SEQ_W'(flag_syn);

    // Decide action and new record contents
    always_comb begin
        act   = ACT_DROP;
        nxt   = cur;
        we    = 1'b0;
        alloc = 1'b0;
        if (!csum_ok) begin
            act = ACT_DROP;
        end else if (flag_syn && !owner) begin
            if (!cur.est || !cur.ack) begin
                act         = ACT_APP;
                we          = 1'b1;
                nxt.est     = 1'b1;
                nxt.syn     = 1'b1;
                nxt.ack     = 1'b0;
                nxt.tuple   = tuple;
                nxt.exp_seq = advanced;
                nxt.seg_ptr = '0;
            end else begin
                act = ACT_DROP;
            end
        end else if (!owner) begin
            act = ACT_FWD;
        end else begin
            we      = 1'b1;
            nxt.ack = cur.ack | flag_ack;
            nxt.syn = cur.syn | flag_syn;
            if (diff == '0) begin
                act         = ACT_APP;
                nxt.exp_seq = advanced;
            end else if (diff[SEQ_W-1]) begin
                act = ACT_FWD;
            end else begin
                act = ACT_BUF;
                if (cur.seg_ptr == '0) begin
                    nxt.seg_ptr = next_ptr;
                    alloc       = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tcp_conn_classifier.sv
// Top level: hashes the header tuple, looks up the connection record,
// applies the policy, writes the record back and registers a one-cycle
// action strobe. Assumes one header per cycle, taken when ready.
module tcp_conn_classifier
    import tcpc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hdr_valid,
    output logic                 hdr_ready,
    input  logic [31:0]          src_ip,
    input  logic [31:0]          dst_ip,
    input  logic [15:0]          src_port,
    input  logic [15:0]          dst_port,
    input  logic                 flag_syn,
    input  logic                 flag_ack,
    input  logic [SEQ_W-1:0]     seq_num,
    input  logic [LEN_W-1:0]     pay_len,
    input  logic                 csum_ok,
    output logic                 act_valid,
    output logic [1:0]           act_code,
    output logic [IDX_W-1:0]     act_index,
    output logic [SEG_PTR_W-1:0] act_seg
);
    logic [TUPLE_W-1:0]   tuple;
    logic [IDX_W-1:0]     idx;
    conn_rec_t            cur_rec, nxt_rec;
    act_e                 act;
    logic                 pol_we, pol_alloc, tbl_we, accept;
    logic [SEG_PTR_W-1:0] next_ptr, ptr_inc;

    assign tuple   = {src_ip, dst_ip, src_port, dst_port};
    assign accept  = hdr_valid && hdr_ready;
    assign tbl_we  = accept && pol_we;
    assign ptr_inc = next_ptr + 1'b1;

    tcpc_hash #(.IDX_W(IDX_W)) u_hash (.tuple(tuple), .idx(idx));

    tcpc_table #(.IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .rd_idx(idx), .rd_rec(cur_rec),
        .we(tbl_we), .wr_idx(idx), .wr_rec(nxt_rec), .ready(hdr_ready)
    );

    tcpc_policy u_policy (
        .cur(cur_rec), .tuple(tuple), .flag_syn(flag_syn), .flag_ack(flag_ack),
        .seq_num(seq_num), .pay_len(pay_len), .csum_ok(csum_ok),
        .next_ptr(next_ptr), .act(act), .nxt(nxt_rec), .we(pol_we),
        .alloc(pol_alloc)
    );

    // Reorder buffer id allocator, never hands out zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            next_ptr <= SEG_PTR_W'(1);
        else if (accept && pol_alloc)
            next_ptr <= (ptr_inc == '0) ? SEG_PTR_W'(1) : ptr_inc;
    end

    // Registered action strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_valid <= 1'b0;
            act_code  <= ACT_DROP;
            act_index <= '0;
            act_seg   <= '0;
        end else begin
            act_valid <= accept;
            act_code  <= act;
            act_index <= idx;
            act_seg   <= (act == ACT_BUF) ? nxt_rec.seg_ptr : '0;
        end
    end

    assert_bad_csum_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !csum_ok) |-> !tbl_we);
    assert_bad_csum_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> ($past(csum_ok) || act_code == ACT_DROP));
    assert_quiet_while_clearing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_ready |=> !act_valid);
    assert_strobe_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> $past(accept));
    assert_buffer_has_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_code == ACT_BUF) |-> act_seg != '0);
    assert_id_never_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        next_ptr != '0);
endmodule

// File: tb/tcp_conn_classifier_bench.sv
module tcp_conn_classifier_bench;
    import tcpc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 4;
    localparam int DEPTH      = 1 << IDX_W;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic [31:0] src_ip = '0, dst_ip = '0;
    logic [15:0] src_port = '0, dst_port = '0;
    logic        flag_syn = 1'b0, flag_ack = 1'b0, csum_ok = 1'b1;
    logic [31:0] seq_num = '0;
    logic [15:0] pay_len = '0;
    logic        act_valid;
    logic [1:0]  act_code;
    logic [IDX_W-1:0] act_index;
    logic [7:0]  act_seg;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcp_conn_classifier #(.IDX_W(IDX_W)) u_tcp_conn_classifier (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .src_ip(src_ip), .dst_ip(dst_ip), .src_port(src_port), .dst_port(dst_port),
        .flag_syn(flag_syn), .flag_ack(flag_ack), .seq_num(seq_num),
        .pay_len(pay_len), .csum_ok(csum_ok), .act_valid(act_valid),
        .act_code(act_code), .act_index(act_index), .act_seg(act_seg)
    );

    // Behavioural reference state
    bit          m_est [DEPTH];
    bit          m_ack [DEPTH];
    logic [95:0] m_tup [DEPTH];
    logic [31:0] m_exp [DEPTH];
    int          m_seg [DEPTH];
    int          m_next = 1;

    bit    p_valid = 0;
    int    p_code = 0, p_idx = 0, p_seg = 0;
    string p_tag = "R2";

    function automatic int mhash(logic [95:0] t);
        int h = 0;
        for (int b = 0; b < 96; b += IDX_W) begin
            h = h ^ int'(t % DEPTH);
            t = t >> IDX_W;
        end
        return h;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Compare outputs of the previous cycle's header against the model
    task automatic compare_pending();
        checks++;
        if (act_valid !== p_valid ||
            (p_valid && (int'(act_code) != p_code || int'(act_index) != p_idx ||
                         int'(act_seg) != p_seg))) begin
            failures++;
            $display("FAIL %s actual v=%0b code=%0d idx=%0d seg=%0d expected v=%0b code=%0d idx=%0d seg=%0d",
                     p_tag, act_valid, act_code, act_index, act_seg,
                     p_valid, p_code, p_idx, p_seg);
        end
    endtask

    // Reference decision for one accepted header
    task automatic model(logic [95:0] t, logic syn, logic ack,
                         logic [31:0] seq, logic [15:0] len, logic ok);
        int  i = mhash(t);
        bit  own = m_est[i] && (m_tup[i] == t);
        int  d;
        p_idx = i; p_seg = 0;
        if (!ok) begin
            p_code = 0;
        end else if (syn && !own) begin
            if (!m_est[i] || !m_ack[i]) begin
                p_code = 1; m_est[i] = 1; m_ack[i] = 0; m_tup[i] = t;
                m_exp[i] = seq + 32'(len) + 1; m_seg[i] = 0;
            end else p_code = 0;
        end else if (!own) begin
            p_code = 2;
        end else begin
            if (ack) m_ack[i] = 1;
            d = int'(seq - m_exp[i]);
            if (d == 0) begin
                p_code = 1; m_exp[i] = seq + 32'(len) + 32'(syn);
            end else if (d < 0) p_code = 2;
            else begin
                p_code = 3;
                if (m_seg[i] == 0) begin
                    m_seg[i] = m_next;
                    m_next = (m_next == 255) ? 1 : m_next + 1;
                end
                p_seg = m_seg[i];
            end
        end
    endtask

    task automatic step(logic v, logic [95:0] t, logic syn, logic ack,
                        logic [31:0] seq, logic [15:0] len, logic ok, string tag);
        @(negedge clk);
        compare_pending();
        hdr_valid = v;
        {src_ip, dst_ip, src_port, dst_port} = t;
        flag_syn = syn; flag_ack = ack; seq_num = seq; pay_len = len; csum_ok = ok;
        p_tag = tag;
        p_valid = v && hdr_ready;
        if (p_valid) model(t, syn, ack, seq, len, ok);
    endtask

    task automatic idle(string tag);
        step(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b1, tag);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stimulus
        logic [95:0] ta, tb, tc, td, tu, tw;
        int low_cycles;
        ta = {32'h0A00_0001, 32'h0A00_0002, 16'd1000, 16'd80};
        tb = ta ^ {64'd0, 16'h0011, 16'd0};
        tc = {32'hC0A8_0105, 32'hC0A8_0203, 16'd4321, 16'd443};
        td = tc ^ {64'd0, 16'h0011, 16'd0};
        tu = {32'h0101_0101, 32'h0202_0202, 16'd7, 16'd9};
        tw = {32'h5566_7788, 32'h1122_3344, 16'd2222, 16'd25};
        for (int k = 0; k < DEPTH; k++) begin
            m_est[k] = 0; m_ack[k] = 0; m_tup[k] = '0; m_exp[k] = '0; m_seg[k] = 0;
        end

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "ready in reset", int'(hdr_ready), 0);
        check("R2", "valid in reset", int'(act_valid), 0);
        rst_n = 1'b1;
        low_cycles = 0;
        while (!hdr_ready && low_cycles < 100) begin
            check("R1", "no action while clearing", int'(act_valid), 0);
            low_cycles++;
            @(negedge clk);
        end
        check("R1", "clear cycles", low_cycles, DEPTH);
        check("R2", "collision pair shares index", mhash(ta), mhash(tb));

        // Opening and in-order data: exp 1 -> 11 -> 31
        step(1, ta, 1, 0, 32'd0,  16'd0,  1, "R4");
        step(1, ta, 0, 1, 32'd1,  16'd10, 1, "R5");
        step(1, ta, 0, 1, 32'd11, 16'd20, 1, "R5");
        step(1, ta, 0, 1, 32'd51, 16'd5,  1, "R7");
        step(1, ta, 0, 1, 32'd31, 16'd20, 1, "R5");
        step(1, ta, 0, 1, 32'd60, 16'd4,  1, "R7");
        step(1, ta, 0, 1, 32'd20, 16'd4,  1, "R6");
        idle("R2");
        step(1, ta, 0, 1, 32'd51, 16'd9,  0, "R3");
        step(1, ta, 0, 1, 32'd51, 16'd0,  1, "R3");
        // Collision with an acknowledged occupant
        step(1, tb, 1, 0, 32'd900, 16'd0, 1, "R9");
        step(1, ta, 0, 0, 32'd51, 16'd4,  1, "R11");
        step(1, tb, 0, 0, 32'd901, 16'd0, 1, "R10");
        // Collision with an unacknowledged occupant
        step(1, tc, 1, 0, 32'd100, 16'd3, 1, "R4");
        step(1, tc, 0, 0, 32'd104, 16'd1, 1, "R5");
        step(1, td, 1, 0, 32'd200, 16'd0, 1, "R8");
        step(1, tc, 0, 0, 32'd105, 16'd0, 1, "R10");
        step(1, td, 0, 1, 32'd201, 16'd8, 1, "R8");
        step(1, tu, 0, 0, 32'd5,   16'd1, 1, "R10");
        step(1, tu, 1, 0, 32'd5,   16'd0, 0, "R3");
        step(1, tu, 0, 0, 32'd6,   16'd0, 1, "R3");
        // Sequence wrap
        step(1, tw, 1, 0, 32'hFFFF_FFF0, 16'd0,    1, "R12");
        step(1, tw, 0, 1, 32'hFFFF_FFF1, 16'h0020, 1, "R12");
        step(1, tw, 0, 1, 32'h0000_0005, 16'd2,    1, "R12");
        step(1, tw, 0, 1, 32'h0000_0100, 16'd2,    1, "R12");
        step(1, tw, 0, 1, 32'h0000_0011, 16'd4,    1, "R12");
        step(1, tw, 0, 1, 32'h0000_0015, 16'd4,    1, "R5");
        idle("R2");
        idle("R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule